// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block sits inside a memory controller and keeps one DRAM rank refreshed. A free-running interval timer produces a refresh demand once per refresh interval. The interval is a parameterised cycle count for normal operation and half that count while the high-temperature input is set. A demand that the command arbiter cannot serve at once is stored in a saturating postponement counter. When that counter is full, the request is marked urgent so that the arbiter puts it ahead of normal traffic.

Once its request is granted, the block does one of two things. In all-bank mode it first asks for a precharge of every bank, waits until every bank reports idle, and then sends a one-cycle auto-refresh command with no row address. The whole rank is marked busy for the programmed refresh cycle time. In per-bank mode it skips the precharge step and sends a one-cycle refresh to a single bank, chosen in rotation. Only that bank is marked busy, so the other banks can keep serving requests.

A window counter adds up refreshes in all-bank equivalents, where one full rotation of per-bank commands counts as one. It pulses a done output on the command that completes each retention window.

Top module: `refresh_sched`

## Requirements
- R1: With the grant and all-idle inputs held high and the temperature input low, consecutive refresh commands are exactly REFI_CYC cycles apart.
- R2: While temp_hot_i is high the interval is REFI_CYC/2 cycles. A change of temp_hot_i is taken up only at the next timer reload, so the interval already running finishes at its old length.
- R3: In all-bank mode, the cycle after a grant raises prech_all_o. It stays high, with no refresh command and no busy flag, until all_idle_i is seen high. ab_ref_o is asserted in the next cycle.
- R4: rank_busy_o is high for exactly rfc_cyc_i cycles, starting with the cycle in which ab_ref_o is high (rfc_cyc_i at least 1; a value of 0 behaves as 1).
- R5: slot_req_o is high only while at least one refresh is pending and no refresh is in progress. Once raised, it stays high until slot_gnt_i is sampled high, and it drops in the cycle after the grant.
- R6: Pending demands saturate at MAX_PEND, and further demands are dropped. urgent_o is high exactly while MAX_PEND demands are pending. After a grant the pending demands are served back to back, one every three cycles when rfc_cyc_i is 1.
- R7: In per-bank mode, pb_ref_o pulses with pb_bank_o equal to the target bank. Targets rotate 0, 1, …, NUM_BANKS-1 and then wrap. bank_busy_o has only the target's bit set (bit i is bank i) for rfc_cyc_i cycles. Meanwhile rank_busy_o and prech_all_o stay low and all_idle_i is not waited for.
- R8: window_done_o pulses together with the refresh command that completes WIN_CMDS all-bank equivalents, where NUM_BANKS per-bank commands count as one.
- R9: While rst_n is low at a clock edge, every output is low in the cycle that follows.
- R10: ab_ref_o and pb_ref_o are each one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_hot_i | input | 1 | High-temperature flag, halves the refresh interval |
| bank_mode_i | input | 1 | 1 selects per-bank refresh, sampled at grant |
| rfc_cyc_i | input | RFC_W | Refresh cycle time in clock cycles, sampled at command |
| slot_gnt_i | input | 1 | Arbiter grant for the refresh slot |
| all_idle_i | input | 1 | All banks of the rank are precharged and idle |
| slot_req_o | output | 1 | Refresh slot request to the arbiter |
| urgent_o | output | 1 | Postponement limit reached, refresh must preempt traffic |
| prech_all_o | output | 1 | Precharge-all request before an all-bank refresh |
| ab_ref_o | output | 1 | One-cycle all-bank auto-refresh command |
| pb_ref_o | output | 1 | One-cycle per-bank refresh command |
| pb_bank_o | output | BANK_W | Target bank of the per-bank command |
| rank_busy_o | output | 1 | Whole rank blocked by an all-bank refresh |
| bank_busy_o | output | NUM_BANKS | Per-bank busy flags during per-bank refresh |
| window_done_o | output | 1 | Pulses on the command that completes a retention window |

## Verification
The interval is measured as the spacing between successive commands, first with the temperature input steady and then with it toggled just after a command. The second case shows whether the timer reloads at the new rate immediately or only at the interval boundary. The refresh cycle time is swept from 1 to 15, which separates an off-by-one busy window from a correct one. The grant is then withheld across nine intervals, so saturation, the urgent flag and the back-to-back drain are all visible in one pass. Per-bank runs go through two full rotations with the idle input low, which shows the rotation order, the single busy bit and the absence of a precharge step. Runs from reset in both modes show where the window pulse lands in each.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: nothing beyond a synthesizable enum.
package refresh_pkg;

    // Sequencer states: waiting, precharging, command cycle, busy tail.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_FIRE = 2'd2,
        ST_BUSY = 2'd3
    } rfsh_state_e;

endpackage

// File: rtl/refi_timer.sv
// Refresh interval timer.
// Counts down one refresh interval and pulses tick_o for one cycle at its
// end. The length of the next interval is picked at reload from hot_i, so a
// temperature change never shortens the interval in progress.
// Assumes: REFI_CYC >= 4 and even.
module refi_timer #(
    parameter int REFI_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    output logic tick_o
);
    localparam int HOT_CYC = REFI_CYC / 2;
    localparam int CW      = $clog2(REFI_CYC);
    localparam logic [CW-1:0] LOAD_NORM = CW'(REFI_CYC - 1);
    localparam logic [CW-1:0] LOAD_HOT  = CW'(HOT_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    // Count down; reload at the end of each interval with the rate seen now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LOAD_NORM;
        end else if (tick_o) begin
            cnt_q <= hot_i ? LOAD_HOT : LOAD_NORM;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1

endmodule

// File: rtl/postpone_ctr.sv
// Postponement counter.
// Holds the number of refresh demands not yet served, saturating at MAX_PEND.
// A demand and a service in the same cycle cancel out.
// Assumes: take_i is only raised while at least one demand is pending.
module postpone_ctr #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic take_i,
    output logic pend_nz_o,
    output logic full_o
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] PEND_MAX = PW'(MAX_PEND);

    logic [PW-1:0] pend_q;

    assign pend_nz_o = (pend_q != '0);
    assign full_o    = (pend_q == PEND_MAX);

    // Add demands, remove served ones, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (tick_i && !take_i) begin
            if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
        end else if (!tick_i && take_i) begin
            pend_q <= pend_q - 1'b1;
        end
    end

    AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_MAX); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_q != '0); // R6

endmodule

// File: rtl/refresh_fsm.sv
// Refresh sequencer.
// Runs the handshake with the arbiter, the precharge-all step (all-bank
// mode), the one-cycle command and the busy window of rfc_i cycles. In
// per-bank mode it rotates a target bank pointer and flags only that bank.
// Assumes: NUM_BANKS >= 2; rfc_i is sampled in the command cycle.
module refresh_fsm
    import refresh_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int RFC_W     = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pend_nz_i,
    input  logic                 gnt_i,
    input  logic                 bank_mode_i,
    input  logic                 all_idle_i,
    input  logic [RFC_W-1:0]     rfc_i,
    output logic                 req_o,
    output logic                 prech_o,
    output logic                 ab_ref_o,
    output logic                 pb_ref_o,
    output logic [BANK_W-1:0]    pb_bank_o,
    output logic                 rank_busy_o,
    output logic [NUM_BANKS-1:0] bank_busy_o,
    output logic                 take_o
);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    rfsh_state_e       state_q;
    logic [RFC_W-1:0]  busy_cnt_q;
    logic              pb_sel_q;
    logic [BANK_W-1:0] bank_ptr_q;
    logic [BANK_W-1:0] busy_bank_q;
    logic              active;
    logic [BANK_W-1:0] tgt_bank;

    assign req_o       = (state_q == ST_IDLE) && pend_nz_i;
    assign prech_o     = (state_q == ST_PRE);
    assign ab_ref_o    = (state_q == ST_FIRE) && !pb_sel_q;
    assign pb_ref_o    = (state_q == ST_FIRE) && pb_sel_q;
    assign pb_bank_o   = bank_ptr_q;
    assign take_o      = (state_q == ST_FIRE);
    assign active      = (state_q == ST_FIRE) || (state_q == ST_BUSY);
    assign rank_busy_o = active && !pb_sel_q;
    assign tgt_bank    = (state_q == ST_FIRE) ? bank_ptr_q : busy_bank_q;

    // One busy flag per bank, set only for the bank being refreshed.
    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank_busy
        assign bank_busy_o[gb] = active && pb_sel_q && (tgt_bank == BANK_W'(gb));
    end

    // Sequencer state, busy countdown, mode latch and bank rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            busy_cnt_q  <= '0;
            pb_sel_q    <= 1'b0;
            bank_ptr_q  <= '0;
            busy_bank_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_o && gnt_i) begin
                        pb_sel_q <= bank_mode_i;
                        state_q  <= bank_mode_i ? ST_FIRE : ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (all_idle_i) state_q <= ST_FIRE;
                end
                ST_FIRE: begin
                    busy_cnt_q  <= (rfc_i > RFC_W'(1)) ? rfc_i - 1'b1 : '0;
                    state_q     <= (rfc_i > RFC_W'(1)) ? ST_BUSY : ST_IDLE;
                    busy_bank_q <= bank_ptr_q;
                    if (pb_sel_q) begin
                        bank_ptr_q <= (bank_ptr_q == LAST_BANK) ? '0 : bank_ptr_q + 1'b1;
                    end
                end
                ST_BUSY: begin
                    busy_cnt_q <= busy_cnt_q - 1'b1;
                    if (busy_cnt_q == RFC_W'(1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !gnt_i |=> req_o); // R5
    AST_PRE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ab_ref_o |-> $past(prech_o) && $past(all_idle_i)); // R3
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_ref_o || pb_ref_o) |=> !(ab_ref_o || pb_ref_o)); // R10
    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ab_ref_o && pb_ref_o)); // R10
    AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_busy_o)); // R7
    AST_RANK_VS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        rank_busy_o |-> bank_busy_o == '0); // R7

endmodule

// File: rtl/window_ctr.sv
// Retention window counter.
// Counts refreshes in all-bank equivalents (NUM_BANKS per-bank commands make
// one) and flags the command that completes a window of WIN_CMDS.
// Assumes: NUM_BANKS >= 2, WIN_CMDS >= 2; commands are one cycle wide.
module window_ctr #(
    parameter int NUM_BANKS = 8,
    parameter int WIN_CMDS  = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ab_ref_i,
    input  logic pb_ref_i,
    output logic done_o
);
    localparam int SW = $clog2(NUM_BANKS);
    localparam int WW = $clog2(WIN_CMDS);
    localparam logic [SW-1:0] SUB_LAST = SW'(NUM_BANKS - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CMDS - 1);

    logic [SW-1:0] sub_q;
    logic [WW-1:0] win_q;
    logic          equiv;

    assign equiv  = ab_ref_i || (pb_ref_i && sub_q == SUB_LAST);
    assign done_o = equiv && (win_q == WIN_LAST);

    // Per-bank sub-count toward one all-bank equivalent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (pb_ref_i) begin
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        end
    end

    // Equivalents within the current retention window, wrapping at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (equiv) begin
            win_q <= (win_q == WIN_LAST) ? '0 : win_q + 1'b1;
        end
    end

    AST_WIN_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ab_ref_i || pb_ref_i)); // R8
    AST_WIN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

endmodule

// File: rtl/refresh_sched.sv
// DRAM refresh interval scheduler for one rank.
// Joins the interval timer, postponement counter, sequencer and window
// counter. Refresh commands carry no row address; the device picks rows.
// Assumes: the arbiter honours urgent_o and routes prech_all_o to a
// precharge-all command; all_idle_i comes from the bank state tracker.
module refresh_sched #(
    parameter int REFI_CYC  = 1560,
    parameter int NUM_BANKS = 8,
    parameter int MAX_PEND  = 8,
    parameter int WIN_CMDS  = 8192,
    parameter int RFC_W     = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 temp_hot_i,
    input  logic                 bank_mode_i,
    input  logic [RFC_W-1:0]     rfc_cyc_i,
    input  logic                 slot_gnt_i,
    input  logic                 all_idle_i,
    output logic                 slot_req_o,
    output logic                 urgent_o,
    output logic                 prech_all_o,
    output logic                 ab_ref_o,
    output logic                 pb_ref_o,
    output logic [BANK_W-1:0]    pb_bank_o,
    output logic                 rank_busy_o,
    output logic [NUM_BANKS-1:0] bank_busy_o,
    output logic                 window_done_o
);
    logic tick;
    logic take;
    logic pend_nz;

    refi_timer #(.REFI_CYC(REFI_CYC)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hot_i  (temp_hot_i),
        .tick_o (tick)
    );

    postpone_ctr #(.MAX_PEND(MAX_PEND)) pend_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .take_i    (take),
        .pend_nz_o (pend_nz),
        .full_o    (urgent_o)
    );

    refresh_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .RFC_W     (RFC_W),
        .BANK_W    (BANK_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_nz_i   (pend_nz),
        .gnt_i       (slot_gnt_i),
        .bank_mode_i (bank_mode_i),
        .all_idle_i  (all_idle_i),
        .rfc_i       (rfc_cyc_i),
        .req_o       (slot_req_o),
        .prech_o     (prech_all_o),
        .ab_ref_o    (ab_ref_o),
        .pb_ref_o    (pb_ref_o),
        .pb_bank_o   (pb_bank_o),
        .rank_busy_o (rank_busy_o),
        .bank_busy_o (bank_busy_o),
        .take_o      (take)
    );

    window_ctr #(
        .NUM_BANKS (NUM_BANKS),
        .WIN_CMDS  (WIN_CMDS)
    ) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ab_ref_i (ab_ref_o),
        .pb_ref_i (pb_ref_o),
        .done_o   (window_done_o)
    );

    AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o && !take |=> slot_req_o || prech_all_o || rank_busy_o
                             || bank_busy_o != '0 || ab_ref_o || pb_ref_o); // R6

endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
    localparam int REFI = 40;
    localparam int NB   = 4;
    localparam int WIN  = 4;
    localparam int PEND = 8;
    localparam int RW   = 6;
    localparam int BW   = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hot = 1'b0, pbm = 1'b0, gnt = 1'b0, idle = 1'b1;
    logic [RW-1:0] rfc = RW'(3);
    logic          req, urg, pre, abr, pbr, rbusy, wdone;
    logic [BW-1:0] pbank;
    logic [NB-1:0] bbusy;

    int n_run = 0, n_fail = 0, cyc = 0, pre_cnt = 0;
    bit done = 1'b0;

    refresh_sched #(
        .REFI_CYC(REFI), .NUM_BANKS(NB), .MAX_PEND(PEND),
        .WIN_CMDS(WIN), .RFC_W(RW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .temp_hot_i(hot), .bank_mode_i(pbm),
        .rfc_cyc_i(rfc), .slot_gnt_i(gnt), .all_idle_i(idle),
        .slot_req_o(req), .urgent_o(urg), .prech_all_o(pre),
        .ab_ref_o(abr), .pb_ref_o(pbr), .pb_bank_o(pbank),
        .rank_busy_o(rbusy), .bank_busy_o(bbusy), .window_done_o(wdone)
    );

    always #2.5 clk = ~clk;                       // 200 MHz
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (pre) pre_cnt <= pre_cnt + 1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cmd(output int at);
        int k = 0;
        step();
        while (!(abr || pbr) && k < 2000) begin step(); k++; end
        at = cyc;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        chk({req, urg, pre, abr, pbr, rbusy, wdone, bbusy} == '0, "R9 outputs in reset",
            int'({req, urg, pre, abr, pbr, rbusy, wdone}), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int a, b, c, d, e, f, g, h, cnt;
        do_reset();
        step(5);
        chk(!req, "R5 no request without demand", req, 0);

        // R1: steady interval
        gnt = 1'b1;
        wait_cmd(a); wait_cmd(b); wait_cmd(c);
        chk(b - a == REFI, "R1 interval", b - a, REFI);
        chk(c - b == REFI, "R1 interval", c - b, REFI);

        // R2: hot halves the interval, only from the next reload
        hot = 1'b1;
        wait_cmd(d); wait_cmd(e); wait_cmd(f);
        chk(d - c == REFI, "R2 running interval kept", d - c, REFI);
        chk(e - d == REFI / 2, "R2 hot interval", e - d, REFI / 2);
        chk(f - e == REFI / 2, "R2 hot interval", f - e, REFI / 2);
        hot = 1'b0;
        wait_cmd(g); wait_cmd(h);
        chk(g - f == REFI / 2, "R2 back to normal at reload", g - f, REFI / 2);
        chk(h - g == REFI, "R2 normal interval", h - g, REFI);

        // R5 / R3: request held, precharge-all waits for idle
        gnt = 1'b0; idle = 1'b0;
        cnt = 0;
        while (!req && cnt < 200) begin step(); cnt++; end
        step(10);
        chk(req && !pre && !abr, "R5 request held without grant", req, 1);
        gnt = 1'b1;
        step();
        chk(!req && pre, "R5 request drops after grant", req, 0);
        step(6);
        chk(pre && !abr && !rbusy, "R3 precharge held until idle", pre, 1);
        idle = 1'b1;
        step();
        chk(abr && !pre, "R3 command after idle", abr, 1);

        // R4 / R10: busy window sweep
        for (int t = 1; t <= 15; t++) begin
            rfc = RW'(t);
            wait_cmd(a);
            cnt = 0;
            while (rbusy && cnt < 100) begin
                cnt++; step();
                if (cnt == 1) chk(!abr, "R10 command one cycle", abr, 0);
            end
            chk(cnt == t, "R4 rank busy length", cnt, t);
        end

        // R6: postponement saturation and drain
        rfc = RW'(1);
        wait_cmd(c);
        gnt = 1'b0;
        step(300);
        chk(req && !urg, "R6 not urgent at seven pending", urg, 0);
        step(40);
        chk(urg, "R6 urgent when full", urg, 1);
        step(30);
        chk(urg, "R6 saturated still urgent", urg, 1);
        gnt = 1'b1;
        cnt = 0;
        for (int i = 0; i < 25; i++) begin
            step();
            if (abr) cnt++;
            if (i == 4) chk(!urg, "R6 urgent clears after first service", urg, 0);
        end
        chk(cnt == PEND, "R6 drained count", cnt, PEND);
        chk(!req, "R6 nothing left pending", req, 0);

        // R7: per-bank rotation
        pbm = 1'b1; idle = 1'b0; rfc = RW'(4);
        b = pre_cnt;
        for (int i = 0; i < 2 * NB; i++) begin
            wait_cmd(a);
            chk(pbr && !abr, "R7 per-bank command", pbr, 1);
            chk(int'(pbank) == i % NB, "R7 rotation order", pbank, i % NB);
            chk(bbusy == NB'(1 << (i % NB)) && !rbusy, "R7 only target busy",
                bbusy, 1 << (i % NB));
            cnt = 0;
            while (bbusy != '0 && cnt < 100) begin cnt++; step(); end
            chk(cnt == 4, "R7 bank busy length", cnt, 4);
        end
        chk(pre_cnt == b, "R7 no precharge in per-bank mode", pre_cnt - b, 0);

        // R8: retention window in both modes
        pbm = 1'b0; idle = 1'b1; hot = 1'b1; rfc = RW'(2);
        do_reset();
        for (int i = 0; i < 2 * WIN; i++) begin
            wait_cmd(a);
            chk(wdone == ((i % WIN) == WIN - 1), "R8 all-bank window", wdone,
                int'((i % WIN) == WIN - 1));
        end
        pbm = 1'b1;
        cnt = 0;
        for (int i = 0; i < NB * WIN; i++) begin
            wait_cmd(a);
            if (wdone) cnt++;
            if (i == NB * WIN - 1) chk(wdone, "R8 per-bank window end", wdone, 1);
        end
        chk(cnt == 1, "R8 one window pulse per-bank", cnt, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule